// File: doc/BRIEF.md
# Arithmetic Flag Generator and Condition Evaluator

This block produces the four arithmetic status flags (negative, zero, carry, overflow) for a 32-bit add or subtract. It takes the two operands, the result that an adder elsewhere has already produced, and an operation select. Carry and overflow are not read from a wider adder. They are derived only from the most significant bits of the two operands and the result, so the block needs no adder of its own.

In the same cycle it decides whether a 4-bit condition field passes against the flag nibble that the processor currently holds. This lets a pipeline stage both predicate an instruction and produce the flags that the instruction will write.

A parameter selects whether both outputs go through one register stage, with an asynchronous active-low reset, or leave the block combinationally. The default is registered.

Top module: `flagcond_top`

## Requirements
- R1: `flagsOut[3]` (negative) equals bit 31 of `opRes`.
- R2: `flagsOut[2]` (zero) is 1 exactly when all 32 bits of `opRes` are zero.
- R3: When `opSub`=0, `flagsOut[1]` (carry) is (a31 & b31) | ((a31 | b31) & ~c31), where a=`opA`, b=`opB` and c=`opRes`. When c = a+b, this equals the carry out of an unsigned 32-bit add.
- R4: When `opSub`=1, `flagsOut[1]` is the inverse of the borrow (~a31 & b31) | ((~a31 | b31) & c31). When c = a-b, this is 1 exactly when a >= b unsigned.
- R5: When `opSub`=0, `flagsOut[0]` (overflow) is (a31 & b31 & ~c31) | (~a31 & ~b31 & c31).
- R6: When `opSub`=1, `flagsOut[0]` is (a31 & ~b31 & ~c31) | (~a31 & b31 & c31).
- R7: `flagsIn` holds N, Z, C, V in bits 3, 2, 1, 0. Codes 0/1 pass on Z set/clear, codes 2/3 on C set/clear, codes 4/5 on N set/clear, and codes 6/7 on V set/clear.
- R8: Code 8 passes on C & ~Z. Code 9 passes on ~C | Z.
- R9: Code 0xA passes on N==V and code 0xB on N!=V. Code 0xC passes on ~Z & (N==V) and code 0xD on Z | (N!=V).
- R10: Code 0xE always passes. Code 0xF never passes.
- R11: With `REG_OUT`=1, both outputs reflect the inputs sampled at the previous rising clock edge. While `rstN` is low, both outputs are 0.
- R12: `condPass` depends only on `condCode` and `flagsIn`. Changing the operands, the result or `opSub` does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opRes | input | 32 | Result of the add or subtract |
| opSub | input | 1 | 0 = add, 1 = subtract |
| condCode | input | 4 | Condition field to evaluate |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| flagsOut | output | 4 | New flags {N,Z,C,V} |
| condPass | output | 1 | 1 when the condition passes |

## Verification
The hardest cases to reach are those where carry and overflow disagree with each other, or where both fire at once. These come from sign patterns at the 32-bit extremes, for example 0x7FFFFFFF+1, 0x80000000+0x80000000 and 0x80000000-1. Random operands almost never land on them, so the stimulus drives each of these boundary pairs directly, for both add and subtract. It also sweeps all 256 combinations of condition code and flag nibble. A phase holds the code and flags fixed while the operands change, to show that the pass bit is independent of them.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;
  localparam int CODE_W  = 4;
  localparam int TERM_N  = 2 ** (CODE_W - 1);
  localparam int FLAG_N  = 3;
  localparam int FLAG_Z  = 2;
  localparam int FLAG_C  = 1;
  localparam int FLAG_V  = 0;

  // Strobes from the condition decoder to the datapath.
  typedef struct packed {
    logic [TERM_N-1:0] termHot;  // one-hot: which base term is tested
    logic              invert;   // odd codes test the complement
  } condStrobe_t;
endpackage

// File: rtl/flagcond_control.sv
module flagcond_control
  import flagcond_pkg::*;
(
  input  logic [CODE_W-1:0] condCode,
  output condStrobe_t       strobe
);
  logic [CODE_W-2:0] termIdx;

  assign termIdx = condCode[CODE_W-1:1];

  always_comb begin
    strobe.termHot = '0;
    strobe.termHot[termIdx] = 1'b1;
    strobe.invert = condCode[0];
  end
endmodule

// File: rtl/flagcond_datapath.sv
module flagcond_datapath
  import flagcond_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opRes,
  input  logic             opSub,
  input  logic [3:0]       flagsIn,
  input  condStrobe_t      strobe,
  output logic [3:0]       flagsOut,
  output logic             condPass
);
  localparam int MSB = WIDTH - 1;

  logic aTop, bTop, cTop;
  logic addCarry, subBorrow, addOvf, subOvf;
  logic [3:0] flagsNext;
  logic passNext;
  logic fN, fZ, fC, fV;
  logic [TERM_N-1:0] terms;

  assign aTop = opA[MSB];
  assign bTop = opB[MSB];
  assign cTop = opRes[MSB];

  // Carry and overflow from the sign bits alone.
  assign addCarry  = (aTop & bTop) | ((aTop | bTop) & ~cTop);
  assign subBorrow = (~aTop & bTop) | ((~aTop | bTop) & cTop);
  assign addOvf    = (aTop & bTop & ~cTop) | (~aTop & ~bTop & cTop);
  assign subOvf    = (aTop & ~bTop & ~cTop) | (~aTop & bTop & cTop);

  always_comb begin
    flagsNext = '0;
    flagsNext[FLAG_N] = cTop;
    flagsNext[FLAG_Z] = ~|opRes;
    flagsNext[FLAG_C] = opSub ? ~subBorrow : addCarry;
    flagsNext[FLAG_V] = opSub ? subOvf : addOvf;
  end

  assign fN = flagsIn[FLAG_N];
  assign fZ = flagsIn[FLAG_Z];
  assign fC = flagsIn[FLAG_C];
  assign fV = flagsIn[FLAG_V];

  // Base terms, indexed by the upper three bits of the condition code.
  assign terms[0] = fZ;
  assign terms[1] = fC;
  assign terms[2] = fN;
  assign terms[3] = fV;
  assign terms[4] = fC & ~fZ;
  assign terms[5] = ~(fN ^ fV);
  assign terms[6] = ~fZ & ~(fN ^ fV);
  assign terms[7] = 1'b1;

  assign passNext = (|(terms & strobe.termHot)) ^ strobe.invert;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagsOut <= '0;
          condPass <= 1'b0;
        end else begin
          flagsOut <= flagsNext;
          condPass <= passNext;
        end
      end
    end else begin : g_comb
      assign flagsOut = flagsNext;
      assign condPass = passNext;
    end
  endgenerate
endmodule

// File: rtl/flagcond_top.sv
module flagcond_top
  import flagcond_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opRes,
  input  logic             opSub,
  input  logic [3:0]       condCode,
  input  logic [3:0]       flagsIn,
  output logic [3:0]       flagsOut,
  output logic             condPass
);
  condStrobe_t strobe;

  flagcond_control u_ctrl (
    .condCode(condCode),
    .strobe  (strobe)
  );

  flagcond_datapath #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .opRes   (opRes),
    .opSub   (opSub),
    .flagsIn (flagsIn),
    .strobe  (strobe),
    .flagsOut(flagsOut),
    .condPass(condPass)
  );
endmodule

// File: rtl/flagcond_checker.sv
module flagcond_checker #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] opRes,
  input logic             opSub,
  input logic [3:0]       condCode,
  input logic [3:0]       flagsIn,
  input logic [3:0]       flagsOut,
  input logic             condPass
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] refA, refB, refC;
  logic             refSub, primed;
  logic [3:0]       refCode, refFlags;

  generate
    if (REG_OUT) begin : g_delay
      always_ff @(posedge clk) begin
        refA     <= opA;
        refB     <= opB;
        refC     <= opRes;
        refSub   <= opSub;
        refCode  <= condCode;
        refFlags <= flagsIn;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) primed <= 1'b0;
        else       primed <= 1'b1;
      end
    end else begin : g_pass
      assign refA     = opA;
      assign refB     = opB;
      assign refC     = opRes;
      assign refSub   = opSub;
      assign refCode  = condCode;
      assign refFlags = flagsIn;
      assign primed   = 1'b1;
    end
  endgenerate

  // Independent widened arithmetic, used only when the result matches it.
  logic [WIDTH:0] uSum, sSum, sDiff;
  logic isSum, isDiff;
  assign uSum   = {1'b0, refA} + {1'b0, refB};
  assign sSum   = {refA[MSB], refA} + {refB[MSB], refB};
  assign sDiff  = {refA[MSB], refA} - {refB[MSB], refB};
  assign isSum  = (refC == uSum[MSB:0]);
  assign isDiff = (refC == refA - refB);

  AST_NEG_BIT:      assert property (@(posedge clk) disable iff (!rstN) primed |-> flagsOut[3] == refC[MSB]); // R1
  AST_ZERO_BIT:     assert property (@(posedge clk) disable iff (!rstN) primed |-> flagsOut[2] == (refC == '0)); // R2
  AST_ADD_CARRY:    assert property (@(posedge clk) disable iff (!rstN) (primed && !refSub && isSum) |-> flagsOut[1] == (uSum != {1'b0, refC})); // R3
  AST_SUB_CARRY:    assert property (@(posedge clk) disable iff (!rstN) (primed && refSub && isDiff) |-> flagsOut[1] == (refA >= refB)); // R4
  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) (primed && !refSub && isSum) |-> flagsOut[0] == (sSum != {refC[MSB], refC})); // R5
  AST_SUB_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) (primed && refSub && isDiff) |-> flagsOut[0] == (sDiff != {refC[MSB], refC})); // R6
  AST_EQ_PASS:      assert property (@(posedge clk) disable iff (!rstN) (primed && refCode == 4'h0) |-> condPass == refFlags[2]); // R7
  AST_CS_PASS:      assert property (@(posedge clk) disable iff (!rstN) (primed && refCode == 4'h2) |-> condPass == refFlags[1]); // R7
  AST_MI_PASS:      assert property (@(posedge clk) disable iff (!rstN) (primed && refCode == 4'h4) |-> condPass == refFlags[3]); // R7
  AST_VS_PASS:      assert property (@(posedge clk) disable iff (!rstN) (primed && refCode == 4'h6) |-> condPass == refFlags[0]); // R7
  AST_ALWAYS_PASS:  assert property (@(posedge clk) disable iff (!rstN) (primed && refCode == 4'hE) |-> condPass); // R10
  AST_NEVER_PASS:   assert property (@(posedge clk) disable iff (!rstN) (primed && refCode == 4'hF) |-> !condPass); // R10
endmodule

bind flagcond_top flagcond_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opRes(opRes), .opSub(opSub),
  .condCode(condCode), .flagsIn(flagsIn), .flagsOut(flagsOut), .condPass(condPass)
);

// File: tb/flagcond_top_tb.sv
module flagcond_top_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB, opRes;
  logic        opSub;
  logic [3:0]  condCode, flagsIn;
  logic [3:0]  flagsOut;
  logic        condPass;

  int checkCnt = 0;
  int failCnt  = 0;

  typedef struct {
    logic [3:0] flags;
    logic       pass;
    logic       sub;
    int         passTag;
  } expect_t;
  expect_t pendQ[$];

  always #4 clk = ~clk;  // 125 MHz

  flagcond_top u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opRes(opRes), .opSub(opSub),
    .condCode(condCode), .flagsIn(flagsIn), .flagsOut(flagsOut), .condPass(condPass)
  );

  task automatic chk(int tag, logic act, logic exp, string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL R%0d %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Flags from the requirement formulas (R1..R6).
  function automatic logic [3:0] refFlags(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic sub);
    logic a1, b1, c1, cy, ov;
    a1 = a[31]; b1 = b[31]; c1 = c[31];
    if (!sub) begin
      cy = (a1 & b1) | ((a1 | b1) & !c1);
      ov = (a1 & b1 & !c1) | (!a1 & !b1 & c1);
    end else begin
      cy = !((!a1 & b1) | ((!a1 | b1) & c1));
      ov = (a1 & !b1 & !c1) | (!a1 & b1 & c1);
    end
    return {c1, (c == 32'd0), cy, ov};
  endfunction

  // Condition outcome from R7..R10.
  function automatic logic refPass(logic [3:0] code, logic [3:0] f);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      4'h0: return z;         4'h1: return !z;
      4'h2: return c;         4'h3: return !c;
      4'h4: return n;         4'h5: return !n;
      4'h6: return v;         4'h7: return !v;
      4'h8: return c && !z;   4'h9: return !c || z;
      4'hA: return n == v;    4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int codeTag(logic [3:0] code);
    if (code < 4'h8) return 7;       // R7
    else if (code < 4'hA) return 8;  // R8
    else if (code < 4'hE) return 9;  // R9
    else return 10;                  // R10
  endfunction

  task automatic compareOut();
    expect_t e;
    if (pendQ.size() == 0) return;
    e = pendQ.pop_front();
    chk(1, flagsOut[3], e.flags[3], "negative flag");
    chk(2, flagsOut[2], e.flags[2], "zero flag");
    chk(e.sub ? 4 : 3, flagsOut[1], e.flags[1], "carry flag");
    chk(e.sub ? 6 : 5, flagsOut[0], e.flags[0], "overflow flag");
    chk(e.passTag, condPass, e.pass, "condition pass");
  endtask

  // One clock: check the outputs of the previous vector, then drive a new one.
  task automatic step(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic sub,
                      logic [3:0] code, logic [3:0] f, int tagOverride);
    expect_t e;
    @(negedge clk);
    compareOut();
    opA = a; opB = b; opRes = c; opSub = sub; condCode = code; flagsIn = f;
    e.flags = refFlags(a, b, c, sub);
    e.pass = refPass(code, f);
    e.sub = sub;
    e.passTag = (tagOverride != 0) ? tagOverride : codeTag(code);
    pendQ.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [31:0] ca[10];
    logic [31:0] cb[10];
    rstN = 1'b0;
    opA = 32'hFFFF_FFFF; opB = 32'h1; opRes = 32'h0; opSub = 1'b0;
    condCode = 4'hE; flagsIn = 4'hF;
    // R11: outputs held at zero during reset even with active inputs.
    repeat (3) begin
      @(negedge clk);
      chk(11, flagsOut == 4'h0, 1'b1, "flags in reset");
      chk(11, condPass, 1'b0, "pass in reset");
    end
    rstN = 1'b1;

    // R7 R8 R9 R10: every code against every flag nibble.
    for (int code = 0; code < 16; code++)
      for (int f = 0; f < 16; f++)
        step(32'h1234_5678, 32'h1111_1111, 32'h2345_6789, f[0], code[3:0], f[3:0], 0);

    // R3 R5 add corners; R4 R6 subtract corners.
    ca = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
           32'h0, 32'h5, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000};
    cb = '{32'h0, 32'h1, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF,
           32'h1, 32'h5, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000};
    for (int i = 0; i < 10; i++) begin
      logic s;
      s = (i >= 5);
      step(ca[i], cb[i], s ? ca[i] - cb[i] : ca[i] + cb[i], s, i[3:0], 4'h6, 0);
    end

    // R1 R2 with consistent results, random operands.
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      logic s;
      a = $urandom(); b = $urandom(); s = i[0];
      if (i % 7 == 0) b = a;
      step(a, b, s ? a - b : a + b, s, 4'($urandom()), 4'($urandom()), 0);
    end

    // Arbitrary result words: formulas still govern the flags.
    for (int i = 0; i < 200; i++)
      step($urandom(), $urandom(), (i % 5 == 0) ? 32'h0 : $urandom(), i[1],
           4'($urandom()), 4'($urandom()), 0);

    // R12: fixed code/flags (code 8, C=1 Z=0), operands changing.
    for (int i = 0; i < 40; i++)
      step($urandom(), $urandom(), $urandom(), i[0], 4'h8, 4'b0010, 12);
    for (int i = 0; i < 40; i++)
      step($urandom(), $urandom(), $urandom(), i[0], 4'hB, 4'b1000, 12);

    @(negedge clk);
    compareOut();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule